// File: doc/BRIEF.md
# Multi-Source Interrupt Mask Controller

This block gathers the interrupt requests of a multi-processor system and reduces them, for each processor, to a single 4-bit priority level. A shared global bank holds 23 level-sensitive device inputs, four asynchronous error inputs and a master mask-all bit. One bank per processor holds fifteen software interrupts and that processor's private timer input. Every source has its own mask bit. A set bit blocks the source and a cleared bit lets it through. Software never rewrites a mask word directly. It writes ones to a set register or to a clear register, and zero bits in the written word change nothing.

Many sources share the same priority level. The encoder takes every pending, unmasked source from the global bank and from the processor's own bank and drives the highest level among them on that processor's output. Error sources always request level 15 and are the only sources that the mask-all bit does not block. Register reads are combinational on the address, and writes take effect at the clock edge.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, global mask readback is 0xF87FFFFF, every processor mask readback is 0x0001FFFE, all pending readbacks are 0 and every level output is 0.
- R2: A write to a mask-set register (offset 4) sets each implemented mask bit written as one. Unimplemented positions (global 26:23, processor 0 and 31:17) stay zero.
- R3: A write to a mask-clear register (offset 5) clears each mask bit written as one, and mask bits written as zero keep their value.
- R4: Global pending (offset 0) shows device inputs at bits 22:0 and error inputs at bits 30:27, one clock edge after the inputs change. A write to offset 0 has no effect.
- R5: Device bits map to levels as follows: 14 and 15 to 12, 16 to 6, 17 to 13, 18 to 4, 19 to 10, 20 to 8, 21 to 9, 22 to 11.
- R6: Bus lanes 0 to 6 (global bits 0 to 6, and again bits 7 to 13) map to levels 2, 3, 5, 7, 9, 11 and 13.
- R7: Each level output is the highest level among the active sources of the global bank and of that processor's bank, and is 0 when no source is active. It updates two edges after a source or mask change is presented.
- R8: While global bit 31 (mask-all) is set, only error sources can raise a level.
- R9: Error bits 30 to 27 each request level 15, and each is individually masked by its own mask bit.
- R10: Writing ones to a processor's soft-set register (offset 2) raises soft interrupts 15:1, and writing ones to its soft-clear register (offset 3) drops them. Soft interrupt n requests level n, and bits 0 and 16 are not written.
- R11: A processor's timer input appears at its pending bit 16 and requests level 14, gated by its own mask bit 16. It affects only that processor.
- R12: The address is {bank, cpu, offset}. Bank 0 with cpu 0 selects the global registers, and bank 1 selects the processor given by cpu. Offset 1 reads the mask, and offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW (5) | Register word address {bank, cpu, offset} |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| dev_src | input | 23 | Level-sensitive device interrupt inputs |
| err_src | input | 4 | Asynchronous error inputs |
| cpu_timer | input | NUM_CPUS | Per-processor timer interrupt inputs |
| irq_level | output | 4*NUM_CPUS | Priority level per processor, processor c at bits 4c+3:4c |

## Verification
Register readback is combinational, so the bench samples a mask value at the falling edge right after the edge that took the write. It samples pending one edge after the input change. A level output is one register behind the pending and mask registers, so the bench checks it only after two rising edges from the moment a source or a mask write is presented. It applies each stimulus at a falling edge and reads at a falling edge, so no comparison ever happens on an edge where the value could still be moving. Sweeps over single bits, over all device bit pairs, over soft interrupts and over error bits keep to this same two-edge rule.

// File: rtl/irq_mask_pkg.sv
// Shared constants, register offsets and the source-to-level map of the
// interrupt mask controller. Assumes 32-bit registers.
package irq_mask_pkg;

    localparam int REG_W        = 32;
    localparam int DEV_W        = 23;
    localparam int ERR_W        = 4;
    localparam int ERR_LSB      = 27;
    localparam int MASK_ALL_BIT = 31;
    localparam int CPU_REG_W    = 17;
    localparam int TIMER_BIT    = 16;
    localparam int LVL_W        = 4;
    localparam int NUM_LVL      = 16;
    localparam int ERR_LEVEL    = 15;
    localparam int TIMER_LEVEL  = 14;
    localparam int LANES        = 7;

    localparam logic [REG_W-1:0]     GLB_IMPL  = 32'hF87F_FFFF;
    localparam logic [CPU_REG_W-1:0] CPU_IMPL  = 17'h1_FFFE;
    localparam logic [CPU_REG_W-1:0] SOFT_IMPL = 17'h0_FFFE;

    typedef enum logic [2:0] {
        OFS_PEND     = 3'd0,
        OFS_MASK     = 3'd1,
        OFS_SOFT_SET = 3'd2,
        OFS_SOFT_CLR = 3'd3,
        OFS_MASK_SET = 3'd4,
        OFS_MASK_CLR = 3'd5
    } reg_ofs_e;

    // Level of bus lane k (0..6)
    function automatic logic [LVL_W-1:0] lane_level(input int k);
        if (k == 0) return LVL_W'(2);
        return LVL_W'(2 * k + 1);
    endfunction

    // Level of global device bit b (0..22)
    function automatic logic [LVL_W-1:0] dev_bit_level(input int b);
        if (b < LANES)     return lane_level(b);
        if (b < 2 * LANES) return lane_level(b - LANES);
        case (b)
            14, 15:  return LVL_W'(12);
            16:      return LVL_W'(6);
            17:      return LVL_W'(13);
            18:      return LVL_W'(4);
            19:      return LVL_W'(10);
            20:      return LVL_W'(8);
            21:      return LVL_W'(9);
            default: return LVL_W'(11);
        endcase
    endfunction

endpackage

// File: rtl/irq_glb_bank.sv
// Global register bank: device and error pending latch plus global mask.
// Assumes at most one of set_we / clr_we is high per cycle.
module irq_glb_bank
    import irq_mask_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [REG_W-1:0] wdata,
    input  logic [DEV_W-1:0] dev_src,
    input  logic [ERR_W-1:0] err_src,
    output logic [REG_W-1:0] pend,
    output logic [REG_W-1:0] mask
);

    logic [REG_W-1:0] pend_nxt;

    // Place the level-sensitive inputs at their register positions
    always_comb begin
        pend_nxt                     = '0;
        pend_nxt[DEV_W-1:0]          = dev_src;
        pend_nxt[ERR_LSB +: ERR_W]   = err_src;
    end

    // Pending follows inputs one cycle late; software cannot alter it
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end

    // Mask register with write-one-to-set and write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)      mask <= GLB_IMPL;
        else if (set_we) mask <= mask | (wdata & GLB_IMPL);
        else if (clr_we) mask <= mask & ~wdata;
    end

endmodule

// File: rtl/irq_cpu_bank.sv
// Per-processor bank: software interrupts 15:1, private timer pending
// and per-processor mask. Assumes one write strobe per cycle.
module irq_cpu_bank
    import irq_mask_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_set_we,
    input  logic                 soft_clr_we,
    input  logic                 mask_set_we,
    input  logic                 mask_clr_we,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 timer_src,
    output logic [CPU_REG_W-1:0] pend,
    output logic [CPU_REG_W-1:0] mask
);

    logic [CPU_REG_W-1:0] soft_q;
    logic                 timer_q;
    logic [CPU_REG_W-1:0] wd;
    logic                 unused_wdata;

    assign wd           = wdata[CPU_REG_W-1:0];
    assign unused_wdata = ^wdata[REG_W-1:CPU_REG_W];

    // Software interrupt latch, set and cleared by one-hot writes
    always_ff @(posedge clk) begin
        if (!rst_n)           soft_q <= '0;
        else if (soft_set_we) soft_q <= soft_q | (wd & SOFT_IMPL);
        else if (soft_clr_we) soft_q <= soft_q & ~wd;
    end

    // Timer input is level-sensitive, sampled once per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) timer_q <= 1'b0;
        else        timer_q <= timer_src;
    end

    // Per-processor mask with split set and clear writes
    always_ff @(posedge clk) begin
        if (!rst_n)           mask <= CPU_IMPL;
        else if (mask_set_we) mask <= mask | (wd & CPU_IMPL);
        else if (mask_clr_we) mask <= mask & ~wd;
    end

    // Combine soft and timer state into the readable pending word
    always_comb begin
        pend            = soft_q;
        pend[TIMER_BIT] = timer_q;
    end

endmodule

// File: rtl/irq_level_enc.sv
// Level encoder for one processor: gathers active global and per-processor
// sources into a level request vector and registers the highest level.
// Assumes the mask-all bit blocks everything except error sources.
module irq_level_enc
    import irq_mask_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_W-1:0]     gpend,
    input  logic [REG_W-1:0]     gmask,
    input  logic [CPU_REG_W-1:0] cpend,
    input  logic [CPU_REG_W-1:0] cmask,
    output logic [LVL_W-1:0]     level
);

    logic [REG_W-1:0]     gact;
    logic [CPU_REG_W-1:0] cact;
    logic                 mask_all;
    logic [NUM_LVL-1:0]   req;
    logic [LVL_W-1:0]     lvl_nxt;
    logic                 unused_bits;

    assign gact        = gpend & ~gmask;
    assign cact        = cpend & ~cmask;
    assign mask_all    = gmask[MASK_ALL_BIT];
    assign unused_bits = ^{gact[ERR_LSB-1:DEV_W], gact[MASK_ALL_BIT], cact[0], req[0]};

    // Collect level requests from every active source
    always_comb begin
        req = '0;
        for (int b = 0; b < DEV_W; b++)
            if (gact[b] && !mask_all) req[dev_bit_level(b)] = 1'b1;
        for (int e = 0; e < ERR_W; e++)
            if (gact[ERR_LSB + e]) req[ERR_LEVEL] = 1'b1;
        for (int n = 1; n < NUM_LVL; n++)
            if (cact[n] && !mask_all) req[n] = 1'b1;
        if (cact[TIMER_BIT] && !mask_all) req[TIMER_LEVEL] = 1'b1;
    end

    // Highest requested level wins
    always_comb begin
        lvl_nxt = '0;
        for (int n = 1; n < NUM_LVL; n++)
            if (req[n]) lvl_nxt = LVL_W'(n);
    end

    // Register the processor level
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= lvl_nxt;
    end

endmodule

// File: rtl/irq_mask_ctrl.sv
// Top of the interrupt mask controller: address decode, read mux, one
// global bank and, per processor, a bank and a level encoder.
// Assumes a single-beat register bus with combinational reads.
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int CPU_SEL_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    parameter int AW        = 1 + CPU_SEL_W + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         bus_addr,
    input  logic                  bus_wen,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic [DEV_W-1:0]      dev_src,
    input  logic [ERR_W-1:0]      err_src,
    input  logic [NUM_CPUS-1:0]   cpu_timer,
    output logic [NUM_CPUS*LVL_W-1:0] irq_level
);

    logic                 bank_sel;
    logic [CPU_SEL_W-1:0] cpu_idx;
    logic [2:0]           ofs;
    logic                 glb_hit;
    logic                 glb_set_we;
    logic                 glb_clr_we;
    logic [REG_W-1:0]     g_pend;
    logic [REG_W-1:0]     g_mask;
    logic [NUM_CPUS-1:0]  cpu_hit;
    logic [CPU_REG_W-1:0] c_pend [NUM_CPUS];
    logic [CPU_REG_W-1:0] c_mask [NUM_CPUS];

    assign bank_sel   = bus_addr[AW-1];
    assign cpu_idx    = bus_addr[3 +: CPU_SEL_W];
    assign ofs        = bus_addr[2:0];
    assign glb_hit    = !bank_sel && (cpu_idx == '0);
    assign glb_set_we = bus_wen && glb_hit && (ofs == OFS_MASK_SET);
    assign glb_clr_we = bus_wen && glb_hit && (ofs == OFS_MASK_CLR);

    irq_glb_bank u_glb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (glb_set_we),
        .clr_we  (glb_clr_we),
        .wdata   (bus_wdata),
        .dev_src (dev_src),
        .err_src (err_src),
        .pend    (g_pend),
        .mask    (g_mask)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic [LVL_W-1:0] lvl;

        assign cpu_hit[c] = bank_sel && (cpu_idx == CPU_SEL_W'(c));

        irq_cpu_bank u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .soft_set_we (bus_wen && cpu_hit[c] && (ofs == OFS_SOFT_SET)),
            .soft_clr_we (bus_wen && cpu_hit[c] && (ofs == OFS_SOFT_CLR)),
            .mask_set_we (bus_wen && cpu_hit[c] && (ofs == OFS_MASK_SET)),
            .mask_clr_we (bus_wen && cpu_hit[c] && (ofs == OFS_MASK_CLR)),
            .wdata       (bus_wdata),
            .timer_src   (cpu_timer[c]),
            .pend        (c_pend[c]),
            .mask        (c_mask[c])
        );

        irq_level_enc u_enc (
            .clk   (clk),
            .rst_n (rst_n),
            .gpend (g_pend),
            .gmask (g_mask),
            .cpend (c_pend[c]),
            .cmask (c_mask[c]),
            .level (lvl)
        );

        assign irq_level[c*LVL_W +: LVL_W] = lvl;
    end

    // Read mux: pending and mask of the addressed bank, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        if (glb_hit) begin
            if (ofs == OFS_PEND)      bus_rdata = g_pend;
            else if (ofs == OFS_MASK) bus_rdata = g_mask;
        end
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (cpu_hit[c]) begin
                if (ofs == OFS_PEND)      bus_rdata = REG_W'(c_pend[c]);
                else if (ofs == OFS_MASK) bus_rdata = REG_W'(c_mask[c]);
            end
        end
    end

endmodule

// File: rtl/irq_mask_ctrl_chk.sv
// Assertion checker for the global bank and processor 0 of irq_mask_ctrl.
module irq_mask_ctrl_chk
    import irq_mask_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 glb_set_we,
    input logic                 glb_clr_we,
    input logic [REG_W-1:0]     wdata,
    input logic [DEV_W-1:0]     dev_src,
    input logic [REG_W-1:0]     g_pend,
    input logic [REG_W-1:0]     g_mask,
    input logic [CPU_REG_W-1:0] c0_pend,
    input logic [CPU_REG_W-1:0] c0_mask,
    input logic [LVL_W-1:0]     lvl0
);

    logic err_act;
    logic any_act;

    assign err_act = |(g_pend[ERR_LSB +: ERR_W] & ~g_mask[ERR_LSB +: ERR_W]);
    assign any_act = err_act || |(g_pend[DEV_W-1:0] & ~g_mask[DEV_W-1:0])
                     || |(c0_pend & ~c0_mask);

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        glb_set_we |=> ((g_mask & $past(wdata & GLB_IMPL)) == $past(wdata & GLB_IMPL))); // R2
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        glb_clr_we |=> ((g_mask & $past(wdata)) == '0)); // R3
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_set_we && !glb_clr_we) |=> $stable(g_mask)); // R3
    AST_PEND_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (g_pend[DEV_W-1:0] == $past(dev_src))); // R4
    AST_ERR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        err_act |=> (lvl0 == LVL_W'(ERR_LEVEL))); // R9
    AST_MASKALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (g_mask[MASK_ALL_BIT] && !err_act) |=> (lvl0 == '0)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !any_act |=> (lvl0 == '0)); // R7
    AST_TIMER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_pend[TIMER_BIT] && !c0_mask[TIMER_BIT] && !g_mask[MASK_ALL_BIT])
        |=> (lvl0 >= LVL_W'(TIMER_LEVEL))); // R11

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_set_we (glb_set_we),
    .glb_clr_we (glb_clr_we),
    .wdata      (bus_wdata),
    .dev_src    (dev_src),
    .g_pend     (g_pend),
    .g_mask     (g_mask),
    .c0_pend    (c_pend[0]),
    .c0_mask    (c_mask[0]),
    .lvl0       (irq_level[3:0])
);

// File: tb/irq_mask_ctrl_tb.sv
`timescale 1ns/1ps
module irq_mask_ctrl_tb;

    localparam int NC = 2;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wen = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [22:0]   dev_src = '0;
    logic [3:0]    err_src = '0;
    logic [NC-1:0] cpu_timer = '0;
    logic [NC*4-1:0] irq_level;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_mask_ctrl #(.NUM_CPUS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_src(dev_src),
        .err_src(err_src), .cpu_timer(cpu_timer), .irq_level(irq_level)
    );

    function automatic logic [AW-1:0] ga(input int o);
        return {2'b00, 3'(o)};
    endfunction
    function automatic logic [AW-1:0] ca(input int c, input int o);
        return {1'b1, 1'(c), 3'(o)};
    endfunction

    // Expected level of a device bit, written from R5 and R6
    function automatic int exp_lvl(input int b);
        int lane [7] = '{2, 3, 5, 7, 9, 11, 13};
        if (b < 7)  return lane[b];
        if (b < 14) return lane[b - 7];
        case (b)
            14: return 12; 15: return 12; 16: return 6; 17: return 13;
            18: return 4;  19: return 10; 20: return 8; 21: return 9;
            default: return 11;
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        step(1);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic int lvl(input int c);
        return int'(irq_level[c*4 +: 4]);
    endfunction

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state, R12 address map
        rd(ga(1), d); check("R1 glb mask", d, 32'hF87F_FFFF);
        rd(ca(0,1), d); check("R1 cpu0 mask", d, 32'h0001_FFFE);
        rd(ca(1,1), d); check("R1 cpu1 mask", d, 32'h0001_FFFE);
        rd(ga(0), d); check("R1 glb pend", d, 0);
        rd(ga(6), d); check("R12 empty offset", d, 0);
        check("R1 levels", irq_level, 0);

        // R2 / R3 split set and clear
        wr(ga(5), 32'h0000_000F); rd(ga(1), d); check("R3 clear", d, 32'hF87F_FFF0);
        wr(ga(4), 32'h0000_0003); rd(ga(1), d); check("R2 set", d, 32'hF87F_FFF3);
        wr(ga(5), 32'h0780_0000); wr(ga(4), 32'h0780_0000);
        rd(ga(1), d); check("R2 unimpl bits", d, 32'hF87F_FFF3);
        wr(ga(5), 32'hFFFF_FFFF); rd(ga(1), d); check("R3 clear all", d, 0);
        wr(ca(0,5), 32'hFFFF_FFFF); wr(ca(1,5), 32'hFFFF_FFFF);
        rd(ca(1,1), d); check("R3 cpu clear", d, 0);
        step(1);
        check("R7 idle level", irq_level, 0);

        // R4 pending follows inputs, write ignored
        dev_src = 23'h5A_5A5A; step(1);
        rd(ga(0), d); check("R4 pend", d, 32'h005A_5A5A);
        wr(ga(0), 32'hFFFF_FFFF); rd(ga(0), d); check("R4 pend write ignored", d, 32'h005A_5A5A);
        dev_src = '0; step(2);

        // R5 / R6 single-bit sweep on both processors
        for (int b = 0; b < 23; b++) begin
            dev_src = 23'(1) << b; step(2);
            check($sformatf("R5 R6 bit%0d cpu0", b), lvl(0), exp_lvl(b));
            check($sformatf("R5 R6 bit%0d cpu1", b), lvl(1), exp_lvl(b));
            wr(ga(4), 32'(1) << b); step(1);
            check($sformatf("R2 masked bit%0d", b), lvl(0), 0);
            wr(ga(5), 32'(1) << b); step(1);
            check($sformatf("R3 unmasked bit%0d", b), lvl(0), exp_lvl(b));
        end
        dev_src = '0; step(2);

        // R7 all pairs, highest wins
        for (int a = 0; a < 23; a++)
            for (int b = a + 1; b < 23; b++) begin
                int e;
                e = exp_lvl(a) > exp_lvl(b) ? exp_lvl(a) : exp_lvl(b);
                dev_src = (23'(1) << a) | (23'(1) << b); step(2);
                check($sformatf("R7 pair %0d %0d", a, b), lvl(1), e);
            end
        dev_src = '0; step(2);
        check("R7 back to zero", irq_level, 0);

        // R9 error sources
        for (int e = 0; e < 4; e++) begin
            err_src = 4'(1) << e; dev_src = 23'h7F_FFFF; step(2);
            check($sformatf("R9 err%0d", e), lvl(0), 15);
            rd(ga(0), d); check($sformatf("R4 err pend%0d", e), d[30:27], 4'(1) << e);
            wr(ga(4), 32'(1) << (27 + e)); step(1);
            check($sformatf("R9 err%0d masked", e), lvl(0), 13);
            wr(ga(5), 32'(1) << (27 + e));
        end
        err_src = '0;

        // R8 mask-all
        wr(ga(4), 32'h8000_0000);
        wr(ca(0,2), 32'h0000_8000); step(1);
        check("R8 mask-all blocks", irq_level, 0);
        err_src = 4'h2; step(2);
        check("R8 error passes", lvl(1), 15);
        err_src = '0; dev_src = '0;
        wr(ga(5), 32'h8000_0000); step(1);
        check("R8 released soft15", lvl(0), 15);
        wr(ca(0,3), 32'h0000_8000); step(1);
        check("R10 soft clear", irq_level, 0);

        // R10 soft sweep on processor 1
        for (int n = 1; n < 16; n++) begin
            wr(ca(1,2), 32'(1) << n); step(1);
            check($sformatf("R10 soft%0d cpu1", n), lvl(1), n);
            check($sformatf("R10 soft%0d cpu0 quiet", n), lvl(0), 0);
            wr(ca(1,3), 32'(1) << n); step(1);
            check($sformatf("R10 soft%0d cleared", n), lvl(1), 0);
        end
        wr(ca(1,2), 32'h0001_0001); rd(ca(1,0), d);
        check("R10 bits 0 16 not written", d, 0);

        // R11 processor timer
        cpu_timer = 2'b01; step(1);
        rd(ca(0,0), d); check("R11 timer pend", d, 32'h0001_0000);
        step(1);
        check("R11 timer cpu0", lvl(0), 14);
        check("R11 timer cpu1 quiet", lvl(1), 0);
        wr(ca(0,4), 32'h0001_0000); step(1);
        check("R11 timer masked", lvl(0), 0);
        rd(ca(0,1), d); check("R2 cpu mask set", d, 32'h0001_0000);
        cpu_timer = '0; step(2);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule